// File: doc/BRIEF.md
# Clock-Qualified Memory Address Decoder

This block turns the 16-bit address of a small 8-bit processor system into chip selects for three regions. A RAM window sits at the bottom of the space, an I/O adapter window sits at 0x6000–0x7FFF, and a ROM window covers the upper half. All selects are active-low. The block is purely combinational: each output follows the address and the clock level with no register in the path.

The RAM select is qualified by the system clock level. It goes low only while the address falls in the RAM window and the clock is high, so the RAM is never enabled during the low phase while the address is still settling. The ROM and I/O selects are not gated by the clock. The 8 KiB hole at 0x4000–0x5FFF selects no device, and a flag marks accesses that land there so that a bus monitor can see stray accesses. The low nibble of the address is passed straight out as the register index of the I/O adapter.

The block has no data stream, so no valid/ready handshake applies. Every pin is a plain level.

Top module: `mad_addr_decode`

## Requirements
- R1: For an address in 0x0000–0x3FFF (bits 15:14 = 00), `ram_cs_n` is 0 while `clk_hi` is 1.
- R2: While `clk_hi` is 0, `ram_cs_n` is 1 for every address.
- R3: `io_cs_n` is 0 exactly for addresses 0x6000–0x7FFF (bits 15:13 = 011), at either clock level.
- R4: `rom_cs_n` is 0 exactly for addresses 0x8000–0xFFFF (bit 15 = 1), at either clock level.
- R5: For an address in 0x4000–0x5FFF (bits 15:13 = 010), all three selects are 1 and `unmapped` is 1.
- R6: `unmapped` is 0 for every address outside 0x4000–0x5FFF.
- R7: `io_reg_sel` equals address bits 3:0 for every address and both clock levels, which gives 16 adapter registers in the I/O window.
- R8: At most one of `ram_cs_n`, `io_cs_n` and `rom_cs_n` is 0 at any time.
- R9: Every address of the stack page 0x0100–0x01FF decodes as RAM. During the high phase it drives `ram_cs_n` to 0 and leaves the other selects at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hi | input | 1 | System clock level; 1 = high phase |
| addr | input | 16 | Processor address bus |
| ram_cs_n | output | 1 | RAM select, active-low, qualified by the high clock phase |
| io_cs_n | output | 1 | I/O adapter select, active-low |
| rom_cs_n | output | 1 | ROM select, active-low |
| unmapped | output | 1 | 1 when the address lies in the unused hole |
| io_reg_sel | output | 4 | Register index for the I/O adapter (address bits 3:0) |

## Verification
The region decode and the clock qualification act together on every RAM access. In the same instant the address selects RAM and the clock level decides whether that select may show. The bench holds each address across one full clock period and judges both phases. Roughly 2 ns into the low phase it expects all selects idle except I/O or ROM. Roughly 2 ns into the high phase it expects the RAM select as well. Window edges such as 0x3FFF/0x4000 and 0x5FFF/0x6000 are placed in both phases, so a select that leaks through the wrong phase or over a boundary shows up as a mismatch.

// File: rtl/mad_pkg.sv
package mad_pkg;
  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_HOLE = 2'd1,
    RGN_IO   = 2'd2,
    RGN_ROM  = 2'd3
  } region_e;

  localparam int NUM_DEV = 3;
  localparam int DEV_RAM = 0;
  localparam int DEV_IO  = 1;
  localparam int DEV_ROM = 2;
endpackage

// File: rtl/mad_prefix_match.sv
module mad_prefix_match #(
  parameter int PFX_W = 2,
  parameter int PFX   = 0
) (
  input  logic [PFX_W-1:0] top_bits,
  output logic             hit
);
  localparam logic [PFX_W-1:0] PATTERN = PFX_W'(PFX);

  always_comb begin
    hit = (top_bits == PATTERN);
  end
endmodule

// File: rtl/mad_phase_gate.sv
module mad_phase_gate #(
  parameter bit GATED = 1'b0
) (
  input  logic clk_hi,
  input  logic hit,
  output logic sel_n
);
  generate
    if (GATED) begin : g_gated
      always_comb sel_n = ~(hit & clk_hi);
    end else begin : g_plain
      logic unused_clk;
      always_comb begin
        unused_clk = clk_hi;
        sel_n      = ~hit;
      end
    end
  endgenerate
endmodule

// File: rtl/mad_reg_index.sv
module mad_reg_index #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] low_bits,
  output logic [IDX_W-1:0] idx
);
  always_comb idx = low_bits;
endmodule

// File: rtl/mad_addr_decode.sv
module mad_addr_decode #(
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 4,
  parameter int RAM_PFX_W = 2,
  parameter int RAM_PFX   = 0,
  parameter int IO_PFX_W  = 3,
  parameter int IO_PFX    = 3,
  parameter int ROM_PFX_W = 1,
  parameter int ROM_PFX   = 1
) (
  input  logic              clk_hi,
  input  logic [ADDR_W-1:0] addr,
  output logic              ram_cs_n,
  output logic              io_cs_n,
  output logic              rom_cs_n,
  output logic              unmapped,
  output logic [IDX_W-1:0]  io_reg_sel
);
  import mad_pkg::*;

  localparam int PFX_WS [NUM_DEV] = '{RAM_PFX_W, IO_PFX_W, ROM_PFX_W};
  localparam int PFX_VS [NUM_DEV] = '{RAM_PFX, IO_PFX, ROM_PFX};
  localparam bit GATE_S [NUM_DEV] = '{1'b1, 1'b0, 1'b0};

  logic [NUM_DEV-1:0] hit;
  logic [NUM_DEV-1:0] sel_n;

  genvar g;
  generate
    for (g = 0; g < NUM_DEV; g++) begin : g_dev
      mad_prefix_match #(
        .PFX_W (PFX_WS[g]),
        .PFX   (PFX_VS[g])
      ) u_match (
        .top_bits (addr[ADDR_W-1 -: PFX_WS[g]]),
        .hit      (hit[g])
      );
      mad_phase_gate #(
        .GATED (GATE_S[g])
      ) u_gate (
        .clk_hi (clk_hi),
        .hit    (hit[g]),
        .sel_n  (sel_n[g])
      );
    end
  endgenerate

  mad_reg_index #(.IDX_W(IDX_W)) u_idx (
    .low_bits (addr[IDX_W-1:0]),
    .idx      (io_reg_sel)
  );

  logic [ADDR_W-1:0] unused_mid;
  always_comb begin
    unused_mid = addr;
    ram_cs_n   = sel_n[DEV_RAM];
    io_cs_n    = sel_n[DEV_IO];
    rom_cs_n   = sel_n[DEV_ROM];
    unmapped   = ~|hit;
  end
endmodule

// File: rtl/mad_checker.sv
module mad_checker (
  input logic        clk_hi,
  input logic [15:0] addr,
  input logic        ram_cs_n,
  input logic        io_cs_n,
  input logic        rom_cs_n,
  input logic        unmapped,
  input logic [3:0]  io_reg_sel
);
  always_comb begin
    a_r2_ram_low_phase: assert (clk_hi || ram_cs_n)
      else $error("R2 RAM select active in low phase");
    a_r8_one_select: assert ($onehot0({~ram_cs_n, ~io_cs_n, ~rom_cs_n}))
      else $error("R8 more than one select active");
    a_r5_hole_quiet: assert (!unmapped || (ram_cs_n && io_cs_n && rom_cs_n))
      else $error("R5 select active in hole");
    a_r7_index: assert (io_reg_sel == addr[3:0])
      else $error("R7 register index mismatch");
    a_r1_high_cover: assert (!clk_hi ||
        $countones({~ram_cs_n, ~io_cs_n, ~rom_cs_n, unmapped}) == 1)
      else $error("R1 high phase must select exactly one target");
    a_r4_rom_upper: assert (!addr[15] || !rom_cs_n)
      else $error("R4 ROM not selected in upper half");
  end
endmodule

bind mad_addr_decode mad_checker u_chk (
  .clk_hi     (clk_hi),
  .addr       (addr),
  .ram_cs_n   (ram_cs_n),
  .io_cs_n    (io_cs_n),
  .rom_cs_n   (rom_cs_n),
  .unmapped   (unmapped),
  .io_reg_sel (io_reg_sel)
);

// File: tb/sim_mad_addr_decode.sv
`timescale 1ns/1ps
module sim_mad_addr_decode;
  logic        clk = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        ram_cs_n, io_cs_n, rom_cs_n, unmapped;
  logic [3:0]  io_reg_sel;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mad_addr_decode u0 (
    .clk_hi     (clk),
    .addr       (addr),
    .ram_cs_n   (ram_cs_n),
    .io_cs_n    (io_cs_n),
    .rom_cs_n   (rom_cs_n),
    .unmapped   (unmapped),
    .io_reg_sel (io_reg_sel)
  );

  // region codes: 0 RAM, 1 hole, 2 I/O, 3 ROM
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {16'h0000, 2'd0}, {16'h3FFF, 2'd0}, {16'h4000, 2'd1}, {16'h5FFF, 2'd1},
    {16'h6000, 2'd2}, {16'h600F, 2'd2}, {16'h7FFF, 2'd2}, {16'h8000, 2'd3},
    {16'hFFFF, 2'd3}, {16'h0100, 2'd0}, {16'h01FF, 2'd0}, {16'h4ABC, 2'd1},
    {16'h6A35, 2'd2}, {16'hC3A7, 2'd3}
  };

  function automatic logic [1:0] region_of(input logic [15:0] a);
    if (a < 16'h4000) return 2'd0;
    if (a < 16'h6000) return 2'd1;
    if (a < 16'h8000) return 2'd2;
    return 2'd3;
  endfunction

  task automatic chk(input string tag, input int got, input int exp, input logic [15:0] a);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%0d expected=%0d", tag, a, got, exp);
    end
  endtask

  task automatic judge(input logic [15:0] a, input logic [1:0] rg, input bit hi);
    chk(hi ? "R1" : "R2", int'(ram_cs_n), (rg == 2'd0 && hi) ? 0 : 1, a);
    chk("R3", int'(io_cs_n), (rg == 2'd2) ? 0 : 1, a);
    chk("R4", int'(rom_cs_n), (rg == 2'd3) ? 0 : 1, a);
    chk(rg == 2'd1 ? "R5" : "R6", int'(unmapped), (rg == 2'd1) ? 1 : 0, a);
    chk("R7", int'(io_reg_sel), int'(a[3:0]), a);
    chk("R8", (ram_cs_n ? 0 : 1) + (io_cs_n ? 0 : 1) + (rom_cs_n ? 0 : 1) <= 1 ? 1 : 0, 1, a);
  endtask

  task automatic apply(input logic [15:0] a, input logic [1:0] rg);
    @(negedge clk);
    #1 addr = a;
    #2 judge(a, rg, 1'b0);
    @(posedge clk);
    #2 judge(a, rg, 1'b1);
  endtask

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // initial state: clock low, address zero, RAM must be idle (R2)
    #1;
    chk("R2", int'(ram_cs_n), 1, addr);
    chk("R6", int'(unmapped), 0, addr);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][17:2], VEC[i][1:0]);
    end

    // R9: stack page edges and middle, high phase must hit RAM only
    for (int s = 16'h0100; s <= 16'h01FF; s += 16'h0055) begin
      apply(16'(s), 2'd0);
      chk("R9", int'({ram_cs_n, io_cs_n, rom_cs_n}), 3'b011, 16'(s));
    end

    // sweep of the space with an odd stride, reference from numeric ranges
    for (int a = 0; a < 65536; a += 17) begin
      apply(16'(a), region_of(16'(a)));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule